// File: doc/BRIEF.md
# Legacy Display Address Routing Decoder

This block sits on the processor request path. For each processor-initiated memory or I/O request it decides whether the request goes to the downstream graphics port or to the default hub interface. It owns an 8-bit configuration register that holds a writable monochrome-adapter-present bit and a read-only bit that carries the sensed graphics I/O buffer voltage. It combines that register with an externally supplied bridge VGA-enable bit, an ISA-enable bit and an I/O base/limit window.

Legacy monochrome and VGA ranges are decoded from memory addresses and from 10-bit I/O port numbers, so all upper-address aliases of a legacy port match as well. A request presents an address, a memory/I-O flag and a byte-enable mask with a valid strobe. The decision is registered and appears on the clock after the request. A separate output flags the illegal setting in which the monochrome bit is set while VGA-enable is clear.

Top module: `legacy_route_decoder`

## Requirements
- R1: After reset the configuration register reads {4'b0000, S, 3'b000}, where S is `vsense_in` sampled during reset. Bits 7:6, 4 and 2:0 always read 0.
- R2: A configuration write changes only bit 5, the monochrome-present flag. Bit 3 keeps its sensed value whatever is written.
- R3: `cfg_illegal` is 1 exactly when `vga_en`=0 and monochrome-present=1.
- R4: A request accepted on a clock edge yields `rsp_valid`=1 on the next edge. `rsp_to_gfx` is 1 for the graphics port and 0 for the hub interface. With no request, `rsp_valid` is 0 on the next edge.
- R5: I/O legacy decode uses only port bits 9:0. Monochrome ports are 3B4h, 3B5h, 3B8h, 3B9h, 3BAh and 3BFh. VGA ports are 3B0h–3BBh and 3C0h–3DFh. Every alias of a monochrome port matches.
- R6: With `vga_en`=0, every monochrome or VGA reference goes to the hub, in both memory and I/O space. This also holds in the illegal setting.
- R7: With `vga_en`=1 and monochrome-present=0, VGA references go to the graphics port, including memory 0B0000h–0B7FFFh. Any I/O request touching port 3BFh or an alias of it goes to the hub.
- R8: With `vga_en`=1 and monochrome-present=1, monochrome references go to the hub: memory 0B0000h–0B7FFFh and the monochrome ports. Other VGA references go to the graphics port. VGA memory is 0A0000h–0BFFFFh.
- R9: An I/O request whose enabled bytes touch any hub-bound legacy port goes to the hub. This holds even if its other bytes are VGA ports or lie inside the I/O window.
- R10: A non-legacy I/O request goes to the graphics port only when two conditions hold. Its dword port address, {addr[15:2],2'b00}, must satisfy `io_base` ≤ address ≤ `io_limit`. Either `isa_en`=0 or addr[9:8]=00 must also hold. Otherwise it goes to the hub.
- R11: A memory request outside 0A0000h–0BFFFFh goes to the hub.
- R12: The I/O byte span is {addr[15:2], i} for each lane i with `req_be[i]`=1, so addr[1:0] is ignored. A request with an all-zero mask touches no legacy port and follows R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsense_in | input | 1 | Sensed buffer-voltage level, captured during reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration write data |
| cfg_rd_data | output | 8 | Configuration register contents |
| cfg_illegal | output | 1 | Illegal VGA/monochrome setting |
| vga_en | input | 1 | Bridge VGA-enable |
| isa_en | input | 1 | Bridge ISA-enable |
| io_base | input | 16 | I/O window lower bound (inclusive) |
| io_limit | input | 16 | I/O window upper bound (inclusive) |
| req_valid | input | 1 | Request strobe |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | 32 | Request address |
| req_be | input | 4 | Request byte-enable mask |
| rsp_valid | output | 1 | Routing result valid |
| rsp_to_gfx | output | 1 | 1 = graphics port, 0 = hub interface |

## Verification
The bench builds the block with the default parameters: 32-bit addresses, 16-bit I/O space and a four-lane byte mask. With four lanes, one request can span legacy and non-legacy ports at once, which puts the overlap-wins-hub rule and the partial-mask cases within reach. With 16 bits of I/O address, aliases in the top bits 15:10 can coincide with the I/O window, so alias decode and window decode can be set against each other.

// File: rtl/legacy_route_pkg.sv
// Shared constants and types for the legacy display routing decoder.
// Assumes the legacy decode is always on a 10-bit I/O port number.
package legacy_route_pkg;

    typedef enum logic {
        DEST_HUB = 1'b0,
        DEST_GFX = 1'b1
    } dest_e;

    localparam int CFG_MONO_BIT  = 5;
    localparam int CFG_VSENS_BIT = 3;
    localparam int PORT_W        = 10;

    localparam logic [PORT_W-1:0] PORT_MONO_ONLY = 10'h3BF;

    localparam logic [31:0] MEM_VGA_LO  = 32'h000A_0000;
    localparam logic [31:0] MEM_VGA_HI  = 32'h000B_FFFF;
    localparam logic [31:0] MEM_MONO_LO = 32'h000B_0000;
    localparam logic [31:0] MEM_MONO_HI = 32'h000B_7FFF;

endpackage

// File: rtl/lrd_cfg_reg.sv
// Configuration register: a writable monochrome-present bit and a read-only
// sensed-voltage bit. Every other bit reads as zero.
// Assumes vsense_in is stable while rst_n is low; its value is held afterwards.
module lrd_cfg_reg
    import legacy_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsense_in,
    input  logic       wr_en,
    input  logic       wr_mono,
    output logic [7:0] rd_data,
    output logic       mono_en
);
    logic mono_q;
    logic vsens_q;

    // Monochrome-present flag: cleared by reset, loaded by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     mono_q <= 1'b0;
        else if (wr_en) mono_q <= wr_mono;
    end

    // Sensed-voltage flag: tracks the input during reset, then holds.
    always_ff @(posedge clk) begin
        if (!rst_n) vsens_q <= vsense_in;
    end

    // Assemble the readable image with reserved bits at zero.
    always_comb begin
        rd_data                = '0;
        rd_data[CFG_MONO_BIT]  = mono_q;
        rd_data[CFG_VSENS_BIT] = vsens_q;
    end

    assign mono_en = mono_q;

endmodule

// File: rtl/lrd_io_lane.sv
// Legacy match for one byte lane of an I/O request.
// The port number is already reduced to its 10 decoded bits, so aliases match.
module lrd_io_lane
    import legacy_route_pkg::*;
(
    input  logic              lane_en,
    input  logic [PORT_W-1:0] port,
    output logic              mono_hit,
    output logic              mono_only_hit,
    output logic              vga_hit
);
    logic mono_port;
    logic vga_port;

    // Classify the port against the monochrome list and the VGA ranges.
    always_comb begin
        unique case (port)
            10'h3B4, 10'h3B5, 10'h3B8,
            10'h3B9, 10'h3BA, 10'h3BF: mono_port = 1'b1;
            default:                   mono_port = 1'b0;
        endcase
        vga_port = ((port >= 10'h3B0) && (port <= 10'h3BB)) ||
                   ((port >= 10'h3C0) && (port <= 10'h3DF));
    end

    assign mono_hit      = lane_en && mono_port;
    assign mono_only_hit = lane_en && (port == PORT_MONO_ONLY);
    assign vga_hit       = lane_en && vga_port;

endmodule

// File: rtl/lrd_route_sel.sv
// Routing choice from the legacy match summaries, the configuration and the
// I/O window result. Purely combinational.
module lrd_route_sel
    import legacy_route_pkg::*;
(
    input  logic  vga_en,
    input  logic  mono_en,
    input  logic  is_io,
    input  logic  any_mono,
    input  logic  any_mono_only,
    input  logic  any_vga,
    input  logic  mem_vga,
    input  logic  mem_mono,
    input  logic  win_ok,
    output dest_e dest
);
    logic legacy_io;
    logic force_hub;

    // I/O references that the legacy rules send to the hub.
    always_comb begin
        legacy_io = any_mono || any_vga;
        force_hub = (!vga_en && legacy_io) ||
                    (vga_en && !mono_en && any_mono_only) ||
                    (vga_en &&  mono_en && any_mono);
    end

    // Final destination for I/O or memory space.
    always_comb begin
        if (is_io) begin
            if (force_hub)      dest = DEST_HUB;
            else if (legacy_io) dest = DEST_GFX;
            else if (win_ok)    dest = DEST_GFX;
            else                dest = DEST_HUB;
        end else begin
            if (!vga_en)                dest = DEST_HUB;
            else if (mono_en && mem_mono) dest = DEST_HUB;
            else if (mem_vga)           dest = DEST_GFX;
            else                        dest = DEST_HUB;
        end
    end

endmodule

// File: rtl/legacy_route_decoder.sv
// Top level: routes each processor request to the graphics port or the hub.
// Decodes legacy ranges lane by lane, applies the I/O window, and registers
// the result so it appears one clock after the request.
// Assumes I/O addresses are dword-based with one byte-enable bit per lane.
module legacy_route_decoder
    import legacy_route_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IO_W   = 16,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsense_in,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wr_data,
    output logic [7:0]        cfg_rd_data,
    output logic              cfg_illegal,
    input  logic              vga_en,
    input  logic              isa_en,
    input  logic [IO_W-1:0]   io_base,
    input  logic [IO_W-1:0]   io_limit,
    input  logic              req_valid,
    input  logic              req_is_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    output logic              rsp_valid,
    output logic              rsp_to_gfx
);
    localparam int LANE_SH = $clog2(BE_W);

    logic              mono_en;
    logic [BE_W-1:0]   lane_mono;
    logic [BE_W-1:0]   lane_mono_only;
    logic [BE_W-1:0]   lane_vga;
    logic [IO_W-1:0]   io_dw;
    logic              win_ok;
    logic              mem_vga;
    logic              mem_mono;
    dest_e             dest;
    logic              unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wr_data[7:CFG_MONO_BIT+1],
                               cfg_wr_data[CFG_MONO_BIT-1:0]};

    lrd_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsense_in (vsense_in),
        .wr_en     (cfg_wr_en),
        .wr_mono   (cfg_wr_data[CFG_MONO_BIT]),
        .rd_data   (cfg_rd_data),
        .mono_en   (mono_en)
    );

    assign cfg_illegal = mono_en && !vga_en;

    // One legacy matcher per byte lane.
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        localparam logic [LANE_SH-1:0] LANE = LANE_SH'(g);
        lrd_io_lane u_lane (
            .lane_en       (req_be[g]),
            .port          ({req_addr[PORT_W-1:LANE_SH], LANE}),
            .mono_hit      (lane_mono[g]),
            .mono_only_hit (lane_mono_only[g]),
            .vga_hit       (lane_vga[g])
        );
    end

    // I/O window and ISA exclusion on the dword port address.
    always_comb begin
        io_dw  = {req_addr[IO_W-1:LANE_SH], {LANE_SH{1'b0}}};
        win_ok = (io_dw >= io_base) && (io_dw <= io_limit) &&
                 (!isa_en || (req_addr[9:8] == 2'b00));
    end

    // Legacy memory range matches.
    always_comb begin
        mem_vga  = (req_addr >= ADDR_W'(MEM_VGA_LO))  && (req_addr <= ADDR_W'(MEM_VGA_HI));
        mem_mono = (req_addr >= ADDR_W'(MEM_MONO_LO)) && (req_addr <= ADDR_W'(MEM_MONO_HI));
    end

    lrd_route_sel u_sel (
        .vga_en        (vga_en),
        .mono_en       (mono_en),
        .is_io         (req_is_io),
        .any_mono      (|lane_mono),
        .any_mono_only (|lane_mono_only),
        .any_vga       (|lane_vga),
        .mem_vga       (mem_vga),
        .mem_mono      (mem_mono),
        .win_ok        (win_ok),
        .dest          (dest)
    );

    // Register the decision one clock after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_to_gfx <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_to_gfx <= req_valid && (dest == DEST_GFX);
        end
    end

endmodule

// File: rtl/lrd_checker.sv
// Assertions on the routing decoder's ports, bound to every instance of it.
module lrd_checker #(
    parameter int ADDR_W = 32,
    parameter int BE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [7:0]        cfg_rd_data,
    input logic              cfg_illegal,
    input logic              vga_en,
    input logic              req_valid,
    input logic              req_is_io,
    input logic [ADDR_W-1:0] req_addr,
    input logic [BE_W-1:0]   req_be,
    input logic              rsp_valid,
    input logic              rsp_to_gfx
);
    localparam int LSH = $clog2(BE_W);

    logic touch_3bf;
    logic mem_outside;

    assign touch_3bf   = req_valid && req_is_io && req_be[BE_W-1] &&
                         ({req_addr[9:LSH], LSH'(BE_W-1)} == 10'h3BF);
    assign mem_outside = req_valid && !req_is_io &&
                         ((req_addr < ADDR_W'(32'h000A_0000)) ||
                          (req_addr > ADDR_W'(32'h000B_FFFF)));

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data & 8'hD7) == 8'h00);

    p_ro_sense_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> $stable(cfg_rd_data[3]));

    p_illegal_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!vga_en && cfg_rd_data[5]) |-> cfg_illegal);

    p_illegal_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vga_en || !cfg_rd_data[5]) |-> !cfg_illegal);

    p_rsp_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_to_gfx));

    p_port3bf_hub_r9: assert property (@(posedge clk) disable iff (!rst_n)
        touch_3bf |=> !rsp_to_gfx);

    p_mem_other_hub_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_outside |=> !rsp_to_gfx);

endmodule

bind legacy_route_decoder lrd_checker #(
    .ADDR_W (ADDR_W),
    .BE_W   (BE_W)
) u_lrd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_rd_data (cfg_rd_data),
    .cfg_illegal (cfg_illegal),
    .vga_en      (vga_en),
    .req_valid   (req_valid),
    .req_is_io   (req_is_io),
    .req_addr    (req_addr),
    .req_be      (req_be),
    .rsp_valid   (rsp_valid),
    .rsp_to_gfx  (rsp_to_gfx)
);

// File: tb/tb_legacy_route_decoder.sv
module tb_legacy_route_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsense_in = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_data = '0;
    logic [7:0]  cfg_rd_data;
    logic        cfg_illegal;
    logic        vga_en = 1'b0;
    logic        isa_en = 1'b0;
    logic [15:0] io_base = 16'h1000;
    logic [15:0] io_limit = 16'h1FFF;
    logic        req_valid = 1'b0;
    logic        req_is_io = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_valid;
    logic        rsp_to_gfx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    legacy_route_decoder dut (
        .clk(clk), .rst_n(rst_n), .vsense_in(vsense_in),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .cfg_illegal(cfg_illegal),
        .vga_en(vga_en), .isa_en(isa_en), .io_base(io_base), .io_limit(io_limit),
        .req_valid(req_valid), .req_is_io(req_is_io), .req_addr(req_addr),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_to_gfx(rsp_to_gfx)
    );

    // Vector: {vga, mono, isa, is_io, addr[31:0], be[3:0], expect_gfx}
    localparam int NV = 26;
    localparam logic [40:0] VEC [NV] = '{
        {4'b0001, 32'h0000_03C0, 4'hF, 1'b0},  // R6 VGA port, vga off
        {4'b0000, 32'h000A_0000, 4'hF, 1'b0},  // R6 VGA memory, vga off
        {4'b0101, 32'h0000_03B4, 4'hF, 1'b0},  // R6 illegal setting
        {4'b1001, 32'h0000_03C0, 4'hF, 1'b1},  // R7 VGA port
        {4'b1001, 32'h0000_03B4, 4'hF, 1'b1},  // R7 mono ports act as VGA
        {4'b1001, 32'h0000_03BC, 4'h8, 1'b0},  // R7 port 3BF to hub
        {4'b1000, 32'h000B_0000, 4'hF, 1'b1},  // R7 mono memory to gfx
        {4'b1101, 32'h0000_03B4, 4'h1, 1'b0},  // R8 mono port
        {4'b1100, 32'h000B_7FFC, 4'hF, 1'b0},  // R8 mono memory top
        {4'b1100, 32'h000B_8000, 4'hF, 1'b1},  // R8 VGA memory after mono
        {4'b1101, 32'h0000_03D4, 4'hF, 1'b1},  // R8 VGA port
        {4'b1101, 32'h0000_07B8, 4'h1, 1'b0},  // R5 alias of 3B8
        {4'b1001, 32'h0000_FFBC, 4'h8, 1'b0},  // R5 alias of 3BF
        {4'b1001, 32'h0000_1BBC, 4'h8, 1'b0},  // R9 alias in window
        {4'b1101, 32'h0000_03B4, 4'hF, 1'b0},  // R9 mono+VGA overlap
        {4'b1101, 32'h0000_03B4, 4'hC, 1'b1},  // R12 only VGA lanes
        {4'b1101, 32'h0000_03B6, 4'hC, 1'b1},  // R12 addr[1:0] ignored
        {4'b0001, 32'h0000_1100, 4'hF, 1'b1},  // R10 in window
        {4'b0011, 32'h0000_1100, 4'hF, 1'b0},  // R10 ISA excluded
        {4'b0011, 32'h0000_1400, 4'hF, 1'b1},  // R10 ISA allowed
        {4'b0001, 32'h0000_2000, 4'hF, 1'b0},  // R10 above limit
        {4'b0001, 32'h0000_1FFC, 4'hF, 1'b1},  // R10 last dword
        {4'b1100, 32'h000C_0000, 4'hF, 1'b0},  // R11 above VGA memory
        {4'b1100, 32'h0009_FFFC, 4'hF, 1'b0},  // R11 below VGA memory
        {4'b1001, 32'h0000_13BC, 4'h7, 1'b1},  // R12 non-legacy lanes
        {4'b0001, 32'h0000_13BC, 4'h0, 1'b1}   // R12 zero mask
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic send(input logic io, input logic [31:0] a, input logic [3:0] be);
        req_valid = 1'b1;
        req_is_io = io;
        req_addr  = a;
        req_be    = be;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset image", 32'(cfg_rd_data), 32'h08);
        check("R4 idle after reset", 32'(rsp_valid), 0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            vga_en = VEC[i][40];
            isa_en = VEC[i][38];
            cfg_write({2'b00, VEC[i][39], 5'b00000});
            send(VEC[i][37], VEC[i][36:5], VEC[i][4:1]);
            check($sformatf("R4 valid vec%0d", i), 32'(rsp_valid), 1);
            check($sformatf("route vec%0d", i), 32'(rsp_to_gfx), 32'(VEC[i][0]));
        end

        // R4: no request gives no response.
        @(negedge clk);
        check("R4 no request", 32'({rsp_valid, rsp_to_gfx}), 0);

        // R2: only bit 5 is writable.
        cfg_write(8'hFF);
        check("R2 write all ones", 32'(cfg_rd_data), 32'h28);
        cfg_write(8'h08);
        check("R2 sense bit held", 32'(cfg_rd_data), 32'h08);

        // R3: illegal flag tracks the setting.
        cfg_write(8'h20);
        vga_en = 1'b0;
        #1;
        check("R3 illegal set", 32'(cfg_illegal), 1);
        vga_en = 1'b1;
        #1;
        check("R3 legal vga+mono", 32'(cfg_illegal), 0);
        cfg_write(8'h00);
        vga_en = 1'b0;
        #1;
        check("R3 legal all off", 32'(cfg_illegal), 0);

        // R1: reset again with the sense input low.
        cfg_write(8'h20);
        vsense_in = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset with sense low", 32'(cfg_rd_data), 32'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule